// File: doc/BRIEF.md
# Tail-Biting Recursive Systematic Encoder

This block encodes one message of N bits with an 8-state recursive systematic convolutional code. The trellis path closes on itself: the encoder starts and ends in the same state, and no termination bits are appended. Because the code has feedback, that shared state depends on every message bit. The block therefore makes two passes over the message.

In the first pass the message is loaded into an internal bit buffer. At the same time it is encoded silently from the all-zero state, and this gives the zero-state end state. A one-cycle solve step then maps that end state, together with N modulo 7, to the unique start state that closes the path. In the second pass the buffered message is read back and encoded from the solved start state. A systematic/parity pair is emitted on each cycle. When the second pass ends, the block compares the state it reached with the start state. A mismatch sets a sticky fault flag.

The feedback taps give the state-transition matrix a period of 7. A length that is a multiple of 7 leaves the closing state undefined, so such a length is refused. A length of zero and a length above the buffer depth are refused as well.

Top module: `tailbite_enc`

## Requirements
- R1: After reset, out_valid, in_ready, busy, len_err and state_err are all 0.
- R2: A start with len equal to 0, len a multiple of 7, or len greater than MAX_LEN (1024) sets len_err to 1. The block stays idle: busy and in_ready stay 0 and no output is produced. The next start with a legal length clears len_err to 0.
- R3: After a legal start, in_ready is 1 until exactly len bits have been accepted. A bit is accepted on a clock edge where in_valid is 1. Cycles with in_valid at 0 accept nothing. in_ready is 0 on the cycle after the last bit is accepted.
- R4: out_valid is 1 for exactly len cycles per block. These cycles come only after all input bits have been accepted, and out_valid is never 1 while in_ready is 1.
- R5: out_code[1] is the systematic bit. It equals the message bits in the order they were loaded.
- R6: out_code[0] is the parity bit. With state bits s1 (newest), s2 and s3, and message bit u, the feedback is a = u^s2^s3 and the parity is a^s1^s3. The next state is s1=a, s2=s1, s3=s2.
- R7: The start state of the emitting pass is the unique 3-bit state from which encoding the whole message returns to that same state.
- R8: state_err is set to 1 if the state at the end of the emitting pass differs from its start state. Once set, it stays at 1 until reset. For a correct encoder it stays 0.
- R9: A start pulse while busy is 1 is ignored. The running block continues unchanged and len_err does not change.
- R10: An all-zero message of legal length produces all-zero output pairs, because the closing state is then the zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a block; sampled only when idle |
| len | input | LEN_W (11) | Block length N, sampled with start |
| in_valid | input | 1 | A message bit is presented on in_bit |
| in_bit | input | 1 | Message bit |
| in_ready | output | 1 | The block is accepting message bits |
| out_valid | output | 1 | out_code holds an emitted pair |
| out_code | output | 2 | {systematic, parity} |
| len_err | output | 1 | The last start carried an illegal length |
| state_err | output | 1 | Sticky: the emitting pass did not close on its start state |
| busy | output | 1 | A block is in progress |

## Verification
The hardest situation to reach is a nonzero closing state for every residue of N modulo 7, paired with both all-zero and dense messages. Only such blocks show whether the solve step picks the right start state. The stimulus uses random lengths that cover all six legal residues, random messages with random input gaps, and directed blocks: an all-zero message, all-ones messages, a single one at the end, and the full 1024-bit buffer. The bench derives its expected start state by trying all eight states over the whole message, so it does not depend on the block's solve step. It also confirms that exactly one candidate state exists for each legal length.

// File: rtl/tbe_pkg.sv
// Package for the tail-biting encoder.
// Holds the phase type, the zero-input state step and the solve function
// that maps (N mod 7, zero-state end state) to the closing start state.
// Assumes state bit 0 is the newest register stage.
package tbe_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_SOLVE,
        PH_EMIT,
        PH_CHECK
    } tbe_phase_t;

    // One trellis step with zero input (multiplication by A)
    function automatic logic [2:0] free_step(input logic [2:0] s);
        logic fb;
        fb = s[1] ^ s[2];
        return {s[1], s[0], fb};
    endfunction

    // Start state x0 with A^r x0 + x0 = zs, found over the 8 states
    function automatic logic [2:0] solve_start(input logic [2:0] r, input logic [2:0] zs);
        logic [2:0] hit;
        logic [2:0] y;
        hit = 3'd0;
        for (int c = 0; c < 8; c++) begin
            y = 3'(c);
            for (int k = 0; k < 6; k++) begin
                if (k < int'(r)) y = free_step(y);
            end
            if ((y ^ 3'(c)) == zs) hit = 3'(c);
        end
        return hit;
    endfunction

endpackage

// File: rtl/tbe_rsc_step.sv
// One step of the recursive systematic code.
// Feedback 1+D^2+D^3, parity 1+D+D^3; purely combinational.
// Assumes st_i[0] is the newest stage, st_i[2] the oldest.
module tbe_rsc_step (
    input  logic [2:0] st_i,
    input  logic       u_i,
    output logic [2:0] nxt_o,
    output logic       par_o
);
    logic fb;

    // Feedback bit, parity bit and shifted state
    always_comb begin
        fb    = u_i ^ st_i[1] ^ st_i[2];
        par_o = fb ^ st_i[0] ^ st_i[2];
        nxt_o = {st_i[1], st_i[0], fb};
    end
endmodule

// File: rtl/tbe_msgbuf.sv
// Bit buffer that holds one message so it can be read a second time.
// One write port and one asynchronous read port. Contents are not reset.
module tbe_msgbuf #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    logic [DEPTH-1:0] mem;

    // Store one message bit
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_bit;
    end

    // Read the bit at the emit index
    always_comb rd_bit = mem[rd_addr];
endmodule

// File: rtl/tailbite_enc.sv
// Two-pass tail-biting encoder top.
// Pass 1 loads and silently encodes from zero. A solve cycle picks the
// closing start state. Pass 2 re-encodes from it and emits {sys, par} pairs.
// A final compare raises a sticky fault if the path did not close.
// Assumes start is sampled only when idle; synchronous active-low reset.
module tailbite_enc #(
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             in_valid,
    input  logic             in_bit,
    output logic             in_ready,
    output logic             out_valid,
    output logic [1:0]       out_code,
    output logic             len_err,
    output logic             state_err,
    output logic             busy
);
    import tbe_pkg::*;

    localparam int ADDR_W = $clog2(MAX_LEN);
    localparam int PERIOD = 7;

    tbe_phase_t       phase;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] n_last;
    logic [2:0]       res;
    logic [2:0]       st;
    logic [2:0]       x0;
    logic [2:0]       st_nxt;
    logic [2:0]       solved;
    logic             step_u;
    logic             step_par;
    logic             rd_bit;
    logic             len_ok;
    logic             wr_en;

    // Legality of the requested length
    always_comb begin
        len_ok = (len != '0) && (len <= LEN_W'(MAX_LEN))
                 && ((len % LEN_W'(PERIOD)) != '0);
    end

    // Input of the step logic: live bit in pass 1, buffered bit in pass 2
    always_comb step_u = (phase == PH_LOAD) ? in_bit : rd_bit;

    // Write strobe for the buffer
    always_comb wr_en = (phase == PH_LOAD) && in_valid;

    // Closing start state from residue and zero-state end state
    always_comb solved = solve_start(res, st);

    tbe_rsc_step u_step (
        .st_i  (st),
        .u_i   (step_u),
        .nxt_o (st_nxt),
        .par_o (step_par)
    );

    tbe_msgbuf #(
        .DEPTH  (MAX_LEN),
        .ADDR_W (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (idx[ADDR_W-1:0]),
        .wr_bit  (in_bit),
        .rd_addr (idx[ADDR_W-1:0]),
        .rd_bit  (rd_bit)
    );

    // Phase sequencing, both passes, solve and closing check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            idx       <= '0;
            n_last    <= '0;
            res       <= 3'd0;
            st        <= 3'd0;
            x0        <= 3'd0;
            out_valid <= 1'b0;
            out_code  <= 2'b00;
            len_err   <= 1'b0;
            state_err <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    out_valid <= 1'b0;
                    if (start) begin
                        if (len_ok) begin
                            len_err <= 1'b0;
                            n_last  <= len - LEN_W'(1);
                            res     <= 3'(len % LEN_W'(PERIOD));
                            idx     <= '0;
                            st      <= 3'd0;
                            phase   <= PH_LOAD;
                        end else begin
                            len_err <= 1'b1;
                        end
                    end
                end
                PH_LOAD: begin
                    if (in_valid) begin
                        st  <= st_nxt;
                        idx <= idx + LEN_W'(1);
                        if (idx == n_last) phase <= PH_SOLVE;
                    end
                end
                PH_SOLVE: begin
                    st    <= solved;
                    x0    <= solved;
                    idx   <= '0;
                    phase <= PH_EMIT;
                end
                PH_EMIT: begin
                    out_valid <= 1'b1;
                    out_code  <= {step_u, step_par};
                    st        <= st_nxt;
                    idx       <= idx + LEN_W'(1);
                    if (idx == n_last) phase <= PH_CHECK;
                end
                PH_CHECK: begin
                    out_valid <= 1'b0;
                    if (st != x0) state_err <= 1'b1;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Edge flags derived from the phase
    always_comb begin
        in_ready = (phase == PH_LOAD);
        busy     = (phase != PH_IDLE);
    end
endmodule

// File: rtl/tailbite_enc_chk.sv
// Assertion checker for tailbite_enc, attached by bind below.
// Watches the edge flags and the closing state at the end of pass 2.
module tailbite_enc_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               in_ready,
    input logic               out_valid,
    input logic               len_err,
    input logic               state_err,
    input logic               busy,
    input tbe_pkg::tbe_phase_t phase,
    input logic [2:0]         st,
    input logic [2:0]         x0
);
    // R4: pairs are only emitted inside a block
    a_r4_valid_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R4: loading and emitting never overlap
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R2: a length fault leaves the block idle
    a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !busy);

    // R8: the closing fault is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state_err |=> state_err);

    // R9: a start while busy leaves the length fault alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_err));

    // R7: the emitting pass returns to its start state
    a_r7_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == tbe_pkg::PH_CHECK) |-> (st == x0));
endmodule

bind tailbite_enc tailbite_enc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .len_err   (len_err),
    .state_err (state_err),
    .busy      (busy),
    .phase     (phase),
    .st        (st),
    .x0        (x0)
);

// File: tb/tb_tailbite_enc.sv
// Self-checking bench: directed corners plus seeded random blocks.
module tb_tailbite_enc;
    localparam int MAXN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] len = '0;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        in_ready, out_valid, len_err, state_err, busy;
    logic [1:0]  out_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    bit       msg [MAXN];
    bit [1:0] expc[MAXN];
    bit [1:0] got [MAXN];

    tailbite_enc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len),
        .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
        .out_valid(out_valid), .out_code(out_code), .len_err(len_err),
        .state_err(state_err), .busy(busy)
    );

    always #2.5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model encode of n bits from state s; returns end state, fills expc
    function automatic bit [2:0] model_run(input int n, input bit [2:0] s0);
        bit [2:0] s;
        bit a;
        s = s0;
        for (int i = 0; i < n; i++) begin
            a = msg[i] ^ s[1] ^ s[2];
            expc[i] = {msg[i], a ^ s[0] ^ s[2]};
            s = {s[1], s[0], a};
        end
        return s;
    endfunction

    // Legal block: expected values by brute-force search over start states
    task automatic run_legal(input int n, input bit gaps, input bit inject);
        int cand = 0;
        bit [2:0] xs = 0;
        int cnt = 0;
        int bad_rdy = 0, bad_sys = 0, bad_par = 0;
        for (int c = 0; c < 8; c++)
            if (model_run(n, 3'(c)) == 3'(c)) begin cand++; xs = 3'(c); end
        chk(cand == 1, "R7 unique closing state", cand, 1);
        void'(model_run(n, xs));
        @(negedge clk); start = 1; len = 11'(n);
        @(negedge clk); start = 0;
        chk(len_err == 0, "R2 legal start clears len_err", len_err, 0);
        for (int i = 0; i < n; i++) begin
            while (gaps && ($urandom % 4 == 0)) begin
                in_valid = 0;
                if (!in_ready) bad_rdy++;
                @(negedge clk);
            end
            if (!in_ready) bad_rdy++;
            in_valid = 1; in_bit = msg[i];
            if (inject && i == n / 2) begin start = 1; len = 11'd0; end
            @(negedge clk);
            start = 0;
        end
        in_valid = 0;
        chk(bad_rdy == 0, "R3 in_ready during load", bad_rdy, 0);
        chk(in_ready == 0, "R3 in_ready low after last bit", in_ready, 0);
        for (int t = 0; t < n + 8; t++) begin
            if (out_valid) begin
                if (cnt < MAXN) got[cnt] = out_code;
                cnt++;
            end
            @(negedge clk);
        end
        chk(cnt == n, "R4 output count", cnt, n);
        for (int i = 0; i < n && i < cnt; i++) begin
            if (got[i][1] != expc[i][1]) bad_sys++;
            if (got[i][0] != expc[i][0]) bad_par++;
        end
        chk(bad_sys == 0, "R5 systematic bits", bad_sys, 0);
        chk(bad_par == 0, "R6 R7 parity bits from closing state", bad_par, 0);
        chk(busy == 0, "R4 idle after block", busy, 0);
        chk(state_err == 0, "R8 no closing fault", state_err, 0);
        if (inject) chk(len_err == 0, "R9 start while busy ignored", len_err, 0);
    endtask

    task automatic run_illegal(input int n);
        int seen = 0;
        @(negedge clk); start = 1; len = 11'(n);
        @(negedge clk); start = 0;
        chk(len_err == 1, "R2 len_err on illegal length", len_err, 1);
        for (int t = 0; t < 5; t++) begin
            if (busy || in_ready || out_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R2 no activity after illegal length", seen, 0);
    endtask

    task automatic fill(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: msg[i] = 0;
                1: msg[i] = 1;
                2: msg[i] = 1'($urandom);
                default: msg[i] = (i == n - 1);
            endcase
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({out_valid, in_ready, busy, len_err, state_err} == 5'b0,
            "R1 reset state", {out_valid, in_ready, busy, len_err, state_err}, 0);

        fill(5, 0); run_legal(5, 0, 0);
        chk(1, "R10 zero message", 0, 0);
        begin
            int nz = 0;
            for (int i = 0; i < 5; i++) if (got[i] != 2'b00) nz++;
            chk(nz == 0, "R10 zero message gives zero code", nz, 0);
        end
        fill(1, 3); run_legal(1, 0, 0);
        fill(6, 1); run_legal(6, 0, 0);
        run_illegal(0);
        run_illegal(7);
        run_illegal(14);
        run_illegal(1029);
        fill(8, 3); run_legal(8, 1, 0);
        fill(40, 2); run_legal(40, 1, 1);
        for (int b = 0; b < 24; b++) begin
            do n = 1 + int'($urandom % 300); while (n % 7 == 0);
            fill(n, 2);
            run_legal(n, 1'($urandom), 0);
        end
        for (int r = 1; r < 7; r++) begin
            fill(r + 14, 1); run_legal(r + 14, 0, 0);
        end
        fill(MAXN, 2); run_legal(MAXN, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule